// File: doc/BRIEF.md
# Satellite Power-State Tracker

This block holds the power state of a PCI function that runs as a satellite (non-host) device. An external host changes the state by writing the two-bit power-state field of the function's power-management control/status register. Local system software marks the function as initialized with a one-cycle strobe. The block keeps two D0 states apart. After reset, and after any return from D3hot, the function sits in an uninitialized D0. The software strobe moves it into active D0.

When the host puts the function into D3hot, a sticky change flag is set. That flag, gated by an enable input, drives an interrupt request so that software can react to the new state. Software clears the flag by writing one to it. The current state can be read through a packed status word that carries the power-state value, the active-D0 indication and the change flag. Configuration-space decode, clock gating and wake signalling are handled elsewhere. The block sees only an already-decoded write strobe carrying the field value.

Top module: `pmsm_top`

## Requirements
- R1: After reset, power_state reads 00, d0_active is 0, chg_flag is 0 and chg_irq is 0.
- R2: A sw_init_pulse while the function is in uninitialized D0 sets d0_active after the next clock edge. In any other state the pulse changes nothing.
- R3: An accepted host write of 01 or 10 puts power_state at 01 (D1) or 10 (D2) after the next edge, and d0_active reads 0.
- R4: An accepted host write of 11 puts power_state at 11 (D3hot) and sets chg_flag after the next edge.
- R5: An accepted host write of 00 has three outcomes. From D3hot it gives uninitialized D0 (d0_active 0). From D1 or D2 it gives active D0 (d0_active 1). In either D0 state it changes nothing.
- R6: chg_flag stays set until chg_clr is asserted, and chg_clr clears it after the next edge. If chg_clr and a D3hot entry fall in the same cycle, the flag ends up set.
- R7: chg_irq equals chg_flag AND chg_irq_en in the same cycle. With IRQ_REG=1 it equals that value one cycle later.
- R8: Host writes to the power-state field are ignored while sat_mode is 0. State and flag keep their values.
- R9: status_word bits [1:0] hold power_state, bit 2 holds d0_active, bit 3 holds chg_flag, and every higher bit reads 0.
- R10: When an accepted host write and sw_init_pulse fall in the same cycle, the host write decides the next state and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sat_mode | input | 1 | Function runs as satellite; enables host power-state writes |
| cfg_ps_wr | input | 1 | Decoded host write strobe to the power-state field |
| cfg_ps_data | input | 2 | Power-state value carried by the host write |
| sw_init_pulse | input | 1 | Software strobe: function is initialized |
| chg_clr | input | 1 | Write-one-to-clear request for the change flag |
| chg_irq_en | input | 1 | Interrupt enable for the change flag |
| power_state | output | 2 | Current power-state field value (00=D0 .. 11=D3hot) |
| d0_active | output | 1 | 1 when in active (initialized) D0 |
| chg_flag | output | 1 | Sticky D3hot-entry flag |
| chg_irq | output | 1 | Interrupt request |
| status_word | output | STAT_W | Packed readback word |

## Verification
Two pairs of events can land in the same cycle. The first is a host write of 11 together with a clear of the change flag. The second is a host write together with the software initialization strobe. The bench walks the function into each of the five states and then applies every combination of host data, mode, strobe and clear from there. Each collision therefore appears from every starting state. Judging is against a small model in the bench. For the first pair the model expects the set to win. For the second it expects the host value to decide the state and the strobe to be dropped.

// File: rtl/pmsm_pkg.sv
package pmsm_pkg;
   typedef enum logic [2:0] {
      PM_D0_UNINIT = 3'd0,
      PM_D0_ACTIVE = 3'd1,
      PM_D1        = 3'd2,
      PM_D2        = 3'd3,
      PM_D3HOT     = 3'd4
   } pm_state_e;

   localparam int PS_W = 2;

   function automatic logic [PS_W-1:0] field_of(pm_state_e s);
      case (s)
         PM_D1:    return 2'b01;
         PM_D2:    return 2'b10;
         PM_D3HOT: return 2'b11;
         default:  return 2'b00;
      endcase
   endfunction
endpackage

// File: rtl/pmsm_fsm.sv
module pmsm_fsm
   import pmsm_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sat_mode,
   input  logic            host_wr,
   input  logic [PS_W-1:0] host_data,
   input  logic            sw_init,
   output pm_state_e       state_q,
   output logic            d3_entry
);
   logic      hit;
   pm_state_e nxt;

   always_comb begin
      hit      = host_wr & sat_mode;
      d3_entry = hit && (host_data == 2'b11);
      nxt      = state_q;
      if (hit) begin
         case (host_data)
            2'b01:   nxt = PM_D1;
            2'b10:   nxt = PM_D2;
            2'b11:   nxt = PM_D3HOT;
            default: begin
               case (state_q)
                  PM_D3HOT:     nxt = PM_D0_UNINIT;
                  PM_D1, PM_D2: nxt = PM_D0_ACTIVE;
                  default:      nxt = state_q;
               endcase
            end
         endcase
      end else if (sw_init && state_q == PM_D0_UNINIT) begin
         nxt = PM_D0_ACTIVE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PM_D0_UNINIT;
      else        state_q <= nxt;
   end

   assert_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !sat_mode && !sw_init) |=> $stable(state_q));
   assert_d3_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && sat_mode && host_data == 2'b11) |=> state_q == PM_D3HOT);
   assert_d3_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && sat_mode && host_data == 2'b00 && state_q == PM_D3HOT)
      |=> state_q == PM_D0_UNINIT);
   assert_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_init && !(host_wr && sat_mode) && state_q == PM_D0_UNINIT)
      |=> state_q == PM_D0_ACTIVE);
endmodule

// File: rtl/pmsm_chg.sv
module pmsm_chg #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   input  logic irq_en,
   output logic flag_q,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_q & irq_en;
         end
         assign irq = irq_q;
         assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |=> !irq);
      end else begin : g_irq_comb
         assign irq = flag_q & irq_en;
         assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |-> !irq);
      end
   endgenerate

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q);
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_evt) |=> !flag_q);
endmodule

// File: rtl/pmsm_readback.sv
module pmsm_readback
   import pmsm_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic [PS_W-1:0]   ps,
   input  logic              active,
   input  logic              flag,
   output logic [STAT_W-1:0] word
);
   localparam int USED_W = PS_W + 2;

   initial assert (STAT_W >= USED_W)
      else $error("pmsm_readback: STAT_W must be at least %0d", USED_W);

   generate
      if (STAT_W > USED_W) begin : g_pad
         assign word = {{(STAT_W-USED_W){1'b0}}, flag, active, ps};
      end else begin : g_exact
         assign word = {flag, active, ps};
      end
   endgenerate
endmodule

// File: rtl/pmsm_top.sv
module pmsm_top
   import pmsm_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sat_mode,
   input  logic              cfg_ps_wr,
   input  logic [1:0]        cfg_ps_data,
   input  logic              sw_init_pulse,
   input  logic              chg_clr,
   input  logic              chg_irq_en,
   output logic [1:0]        power_state,
   output logic              d0_active,
   output logic              chg_flag,
   output logic              chg_irq,
   output logic [STAT_W-1:0] status_word
);
   pm_state_e st;
   logic      d3_set;

   pmsm_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .host_wr(cfg_ps_wr),
      .host_data(cfg_ps_data), .sw_init(sw_init_pulse),
      .state_q(st), .d3_entry(d3_set)
   );

   pmsm_chg #(.IRQ_REG(IRQ_REG)) u_chg (
      .clk(clk), .rst_n(rst_n), .set_evt(d3_set), .clr_req(chg_clr),
      .irq_en(chg_irq_en), .flag_q(chg_flag), .irq(chg_irq)
   );

   assign power_state = field_of(st);
   assign d0_active   = (st == PM_D0_ACTIVE);

   pmsm_readback #(.STAT_W(STAT_W)) u_rb (
      .ps(power_state), .active(d0_active), .flag(chg_flag), .word(status_word)
   );

   assert_d3_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (power_state == 2'b11 && $past(power_state) != 2'b11) |-> chg_flag);
   assert_host_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ps_wr && sat_mode && sw_init_pulse && cfg_ps_data == 2'b11)
      |=> !d0_active);
endmodule

// File: tb/tb_pmsm_top.sv
module tb_pmsm_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sat_mode = 1'b0, cfg_ps_wr = 1'b0, sw_init_pulse = 1'b0;
   logic       chg_clr = 1'b0, chg_irq_en = 1'b0;
   logic [1:0] cfg_ps_data = 2'b00;
   logic [1:0] power_state;
   logic       d0_active, chg_flag, chg_irq;
   logic [7:0] status_word;

   int total = 0, bad = 0;
   bit finished = 0;

   // model: 0 uninit D0, 1 active D0, 2 D1, 3 D2, 4 D3hot
   int  m_st = 0;
   bit  m_flag = 0;
   bit  m_en = 0;

   pmsm_top dut (
      .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .cfg_ps_wr(cfg_ps_wr),
      .cfg_ps_data(cfg_ps_data), .sw_init_pulse(sw_init_pulse),
      .chg_clr(chg_clr), .chg_irq_en(chg_irq_en), .power_state(power_state),
      .d0_active(d0_active), .chg_flag(chg_flag), .chg_irq(chg_irq),
      .status_word(status_word)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] exp_word();
      logic [1:0] ps;
      ps = (m_st == 2) ? 2'b01 : (m_st == 3) ? 2'b10 : (m_st == 4) ? 2'b11 : 2'b00;
      return {4'b0000, m_flag, (m_st == 1), ps};
   endfunction

   task automatic check_outputs(input string tag);
      total++;
      if (status_word !== exp_word()) begin
         bad++;
         $display("FAIL %s status_word actual=%b expected=%b", tag, status_word, exp_word());
      end
      total++;
      if (chg_irq !== (m_flag & m_en)) begin
         bad++;
         $display("FAIL R7 chg_irq actual=%b expected=%b", chg_irq, m_flag & m_en);
      end
   endtask

   task automatic step(input bit sat, input bit wr, input logic [1:0] d,
                       input bit init, input bit clr, input bit en);
      bit acc;
      string tag;
      @(negedge clk);
      sat_mode = sat; cfg_ps_wr = wr; cfg_ps_data = d;
      sw_init_pulse = init; chg_clr = clr; chg_irq_en = en;
      acc = wr & sat;
      if (wr && !sat)          tag = "R8";
      else if (acc && init)    tag = "R10";
      else if (acc && d == 3)  tag = (clr ? "R6" : "R4");
      else if (acc && d == 0)  tag = "R5";
      else if (acc)            tag = "R3";
      else if (init)           tag = "R2";
      else if (clr)            tag = "R6";
      else                     tag = "R9";
      if (acc) begin
         case (d)
            2'd1: m_st = 2;
            2'd2: m_st = 3;
            2'd3: m_st = 4;
            default: m_st = (m_st == 4) ? 0 : (m_st == 2 || m_st == 3) ? 1 : m_st;
         endcase
      end else if (init && m_st == 0) m_st = 1;
      m_flag = (acc && d == 3) | (m_flag & ~clr);
      m_en = en;
      @(posedge clk);
      #2;
      check_outputs(tag);
   endtask

   task automatic reach(input int target);
      step(1, 1, 2'd3, 0, 0, 0);
      case (target)
         0: step(1, 1, 2'd0, 0, 0, 0);
         1: begin step(1, 1, 2'd0, 0, 0, 0); step(0, 0, 2'd0, 1, 0, 0); end
         2: step(1, 1, 2'd1, 0, 0, 0);
         3: step(1, 1, 2'd2, 0, 0, 0);
         default: ;
      endcase
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      total++;
      if (power_state !== 2'b00 || d0_active !== 1'b0 || chg_flag !== 1'b0 || chg_irq !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset actual=%b%b%b%b expected=00000", power_state, d0_active, chg_flag, chg_irq);
      end
      @(negedge clk); rst_n = 1'b1;
      check_outputs("R1");
      // R2: init ignored outside uninitialized D0, taken inside it
      step(1, 0, 2'd0, 1, 0, 1);
      step(1, 0, 2'd0, 1, 0, 1);
      // exhaustive sweep: start state x mode x data x init x clear
      for (int s = 0; s < 5; s++)
         for (int sat = 0; sat < 2; sat++)
            for (int d = 0; d < 4; d++)
               for (int ini = 0; ini < 2; ini++)
                  for (int c = 0; c < 2; c++) begin
                     reach(s);
                     step(sat[0], 1, d[1:0], ini[0], c[0], d[0] ^ c[0]);
                     step(1, 0, 2'd0, 0, 0, 1);
                  end
      // R6: flag persists until cleared, with enable toggling (R7)
      step(1, 1, 2'd3, 0, 0, 1);
      step(1, 0, 2'd0, 0, 0, 0);
      step(1, 0, 2'd0, 0, 0, 1);
      step(1, 0, 2'd0, 0, 1, 1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule